// File: doc/BRIEF.md
# Multiplier-Scaled Watchdog Timer

This block supervises a host by counting down a programmable interval and acting when the host fails to touch it in time. The whole setup lives in one 8-bit configuration byte: a 5-bit multiplier, a 2-bit resolution code that picks the time step, and a steering bit. The interval is the multiplier times the step. Every write of the byte restarts the count. A multiplier of zero leaves the watchdog idle.

On expiry the steering bit picks the action. With steering clear, the block raises an interrupt request. The request stays up until the host rewrites the byte or power fails. With steering set, the block drives a reset request for a fixed number of timebase ticks. It also wipes its own configuration byte to zero, so after that reset the watchdog is idle until software arms it again. Every expiry sets a sticky watchdog flag, which a flag-read strobe clears. A power-fail input disarms the watchdog at once.

Time is measured in pulses of a timebase enable. `UNIT_TICKS` pulses make one sixteenth of a second. `RST_TICKS` pulses make the reset pulse, which is meant to be close to 100 ms. The defaults assume a 64 Hz enable.

Top module: `wdg_top`

## Requirements
- R1: `cfg_rd` returns the last accepted configuration byte. Bit 7 is the steering bit, bits 6..2 are the multiplier and bits 1..0 are the resolution code.
- R2: The timeout is the multiplier times the resolution, times `UNIT_TICKS` enabled ticks. Resolution 00 is 1 unit, 01 is 4 units, 10 is 16 units and 11 is 64 units, where one unit is 1/16 s. With `tick_en` held high, the expiry takes effect on the clock edge that is exactly that many cycles after the write edge.
- R3: A multiplier of zero disables the watchdog: no interrupt, no reset and no flag, whatever the resolution.
- R4: Any accepted write restarts the timeout period from zero.
- R5: With steering 0, an expiry sets `irq_req`. It stays set, even across a flag clear, until an accepted write or `pwr_fail` drops it on the next edge.
- R6: With steering 1, an expiry sets `rst_req` for exactly `RST_TICKS` enabled ticks and clears the configuration byte to 0x00 on the same edge. Writes are ignored while `rst_req` is high, and no further expiry occurs afterwards.
- R7: Every expiry sets `wd_flag`. A `flag_clr` strobe clears it on the next edge, but an expiry on the same edge wins and the flag stays set.
- R8: `pwr_fail` clears the configuration byte, drops `irq_req` and holds off writes while it is high.
- R9: The count advances only on cycles where `tick_en` is high. With `tick_en` low the watchdog never expires.
- R10: A synchronous active-high `rst` clears `rst_req`, `irq_req`, `wd_flag` and `cfg_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timebase enable, one pulse per tick |
| wr_en | input | 1 | Configuration byte write strobe |
| wr_data | input | 8 | Configuration byte data |
| flag_clr | input | 1 | Flag-read strobe that clears the watchdog flag |
| pwr_fail | input | 1 | Power failure indication |
| rst_req | output | 1 | Reset request pulse |
| irq_req | output | 1 | Interrupt request |
| wd_flag | output | 1 | Sticky watchdog timeout flag |
| cfg_rd | output | 8 | Current configuration byte |

## Verification
The assertions assume that `tick_en`, `wr_en`, `flag_clr` and `pwr_fail` are synchronous single-bit levels sampled on the rising edge. They also assume that a write never lands on the same edge as an expiry, since the write itself restarts the count. The stimulus changes every input on the falling edge. It holds `tick_en` high except in the gating test, which makes expiry edges exact multiples of `UNIT_TICKS`. Writes during a reset pulse and during power failure are applied on purpose, to exercise the hold-off paths.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int MULT_W  = 5;
    localparam int SCALE_W = 7;
    localparam int LIMIT_W = 12;

    typedef enum logic [1:0] {
        RES_SIXTEENTH = 2'b00,
        RES_QUARTER   = 2'b01,
        RES_ONE       = 2'b10,
        RES_FOUR      = 2'b11
    } wdg_res_e;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        wdg_res_e          res;
    } wdg_cfg_t;

    // number of 1/16 s units in one resolution step
    function automatic logic [SCALE_W-1:0] res_units(input wdg_res_e r);
        case (r)
            RES_SIXTEENTH: res_units = 7'd1;
            RES_QUARTER:   res_units = 7'd4;
            RES_ONE:       res_units = 7'd16;
            default:       res_units = 7'd64;
        endcase
    endfunction

    function automatic logic [LIMIT_W-1:0] limit_units(input wdg_cfg_t c);
        limit_units = LIMIT_W'(c.mult) * LIMIT_W'(res_units(c.res));
    endfunction

endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
    parameter int UNIT_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic unit_stb
);
    generate
        if (UNIT_TICKS <= 1) begin : g_direct
            assign unit_stb = run && tick && !clr;
        end else begin : g_count
            localparam int CW = $clog2(UNIT_TICKS);
            logic [CW-1:0] cnt;
            logic          wrap;

            assign wrap     = (cnt == CW'(UNIT_TICKS - 1));
            assign unit_stb = run && tick && !clr && wrap;

            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    cnt <= '0;
                end else if (run && tick) begin
                    cnt <= wrap ? '0 : cnt + 1'b1;
                end
            end

            // R9
            hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
                (!tick && !clr) |=> $stable(cnt));
        end
    endgenerate
endmodule

// File: rtl/wdg_timeout.sv
module wdg_timeout
    import wdg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               unit_stb,
    input  logic [LIMIT_W-1:0] limit,
    output logic               expire
);
    logic [LIMIT_W-1:0] ucnt;

    assign expire = unit_stb && (limit != '0) && (ucnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ucnt <= '0;
        end else if (unit_stb) begin
            ucnt <= expire ? '0 : ucnt + 1'b1;
        end
    end

    // R2
    count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (limit != '0) |-> (ucnt < limit));
endmodule

// File: rtl/wdg_rstpulse.sv
module wdg_rstpulse #(
    parameter int RST_TICKS = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic active
);
    localparam int PW = (RST_TICKS > 1) ? $clog2(RST_TICKS) : 1;

    logic [PW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            pcnt   <= '0;
        end else if (start) begin
            active <= 1'b1;
            pcnt   <= '0;
        end else if (active && tick) begin
            if (pcnt == PW'(RST_TICKS - 1)) begin
                active <= 1'b0;
            end
            pcnt <= pcnt + 1'b1;
        end
    end

    // R6
    pulse_end_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(tick));
    // R6
    pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> active);
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int UNIT_TICKS = 4,
    parameter int RST_TICKS  = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       flag_clr,
    input  logic       pwr_fail,
    output logic       rst_req,
    output logic       irq_req,
    output logic       wd_flag,
    output logic [7:0] cfg_rd
);
    wdg_cfg_t           cfg_q;
    logic               accept_wr;
    logic               restart;
    logic               run;
    logic               unit_stb;
    logic               expire;
    logic [LIMIT_W-1:0] limit;

    assign accept_wr = wr_en && !pwr_fail && !rst_req;
    assign restart   = accept_wr || pwr_fail;
    assign run       = (cfg_q.mult != '0) && !restart;
    assign limit     = limit_units(cfg_q);
    assign cfg_rd    = cfg_q;

    wdg_prescale #(.UNIT_TICKS(UNIT_TICKS)) i_prescale (
        .clk      (clk),
        .rst      (rst),
        .clr      (restart),
        .run      (run),
        .tick     (tick_en),
        .unit_stb (unit_stb)
    );

    wdg_timeout i_timeout (
        .clk      (clk),
        .rst      (rst),
        .clr      (restart),
        .unit_stb (unit_stb),
        .limit    (limit),
        .expire   (expire)
    );

    wdg_rstpulse #(.RST_TICKS(RST_TICKS)) i_rstpulse (
        .clk    (clk),
        .rst    (rst),
        .start  (expire && cfg_q.steer),
        .tick   (tick_en),
        .active (rst_req)
    );

    always_ff @(posedge clk) begin
        if (rst || pwr_fail) begin
            cfg_q <= wdg_cfg_t'(8'h00);
        end else if (expire && cfg_q.steer) begin
            cfg_q <= wdg_cfg_t'(8'h00);
        end else if (accept_wr) begin
            cfg_q <= wdg_cfg_t'(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            irq_req <= 1'b0;
        end else if (expire && !cfg_q.steer) begin
            irq_req <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wd_flag <= 1'b0;
        end else if (expire) begin
            wd_flag <= 1'b1;
        end else if (flag_clr) begin
            wd_flag <= 1'b0;
        end
    end

    // R6
    steer_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && cfg_q.steer) |=> (rst_req && cfg_rd == 8'h00));
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> wd_flag);
    // R5
    irq_drop_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rst_req) |=> !irq_req);
    // R8
    pwr_fail_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> (!irq_req && cfg_rd == 8'h00));
    // R3
    irq_needs_mult_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> ($past(cfg_rd[6:2]) != 5'd0));
endmodule

// File: tb/test_wdg_top.sv
module test_wdg_top;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT_TICKS = 4;
    localparam int RST_TICKS  = 6;
    localparam int NVEC       = 5;

    // configuration byte and expected expiry distance in cycles (R2)
    localparam logic [7:0] VEC_CFG  [NVEC] = '{8'h0C, 8'h09, 8'h06, 8'h07, 8'h7C};
    localparam int         VEC_WAIT [NVEC] = '{12, 32, 64, 256, 124};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       flag_clr = 1'b0;
    logic       pwr_fail = 1'b0;
    logic       rst_req, irq_req, wd_flag;
    logic [7:0] cfg_rd;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdg_top #(.UNIT_TICKS(UNIT_TICKS), .RST_TICKS(RST_TICKS)) i_wdg_top (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_data(wr_data),
        .flag_clr(flag_clr), .pwr_fail(pwr_fail), .rst_req(rst_req),
        .irq_req(irq_req), .wd_flag(wd_flag), .cfg_rd(cfg_rd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        edges(1);
        wr_en = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        edges(1);
        flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        edges(2);
        // R10 reset state
        chk("R10 rst_req", rst_req, 0);
        chk("R10 irq_req", irq_req, 0);
        chk("R10 wd_flag", wd_flag, 0);
        chk("R10 cfg_rd", cfg_rd, 0);
        rst = 1'b0;
        edges(1);

        // R2 vector table, steering 0
        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC_CFG[i]);
            chk("R1 readback", cfg_rd, VEC_CFG[i]);
            edges(VEC_WAIT[i] - 1);
            chk("R2 irq before expiry", irq_req, 0);
            chk("R7 flag before expiry", wd_flag, 0);
            edges(1);
            chk("R2 irq at expiry", irq_req, 1);
            chk("R7 flag at expiry", wd_flag, 1);
            chk("R5 no reset when steering 0", rst_req, 0);
            clear_flag();
            chk("R7 flag cleared", wd_flag, 0);
            chk("R5 irq survives flag clear", irq_req, 1);
            do_write(8'h00);
            chk("R5 write drops irq", irq_req, 0);
        end

        // R3 zero multiplier with largest resolution
        do_write(8'h03);
        edges(300);
        chk("R3 irq", irq_req, 0);
        chk("R3 flag", wd_flag, 0);
        chk("R3 rst_req", rst_req, 0);

        // R4 restart
        do_write(8'h0C);
        edges(8);
        do_write(8'h0C);
        edges(11);
        chk("R4 no early expiry", irq_req, 0);
        edges(1);
        chk("R4 expiry after restart", irq_req, 1);
        do_write(8'h00);
        clear_flag();

        // R9 tick gating
        tick_en = 1'b0;
        do_write(8'h0C);
        edges(100);
        chk("R9 no expiry without ticks", irq_req, 0);
        tick_en = 1'b1;
        edges(11);
        chk("R9 not yet", irq_req, 0);
        edges(1);
        chk("R9 expiry", irq_req, 1);
        do_write(8'h00);
        clear_flag();

        // R7 expiry wins over flag clear
        do_write(8'h0C);
        edges(11);
        flag_clr = 1'b1;
        edges(1);
        flag_clr = 1'b0;
        chk("R7 set wins over clear", wd_flag, 1);
        do_write(8'h00);
        clear_flag();

        // R6 reset steering
        do_write(8'h8C);
        edges(11);
        chk("R6 no pulse yet", rst_req, 0);
        edges(1);
        chk("R6 pulse starts", rst_req, 1);
        chk("R6 cfg cleared", cfg_rd, 8'h00);
        chk("R6 flag set", wd_flag, 1);
        chk("R6 no irq", irq_req, 0);
        do_write(8'h0C);
        chk("R6 write ignored in pulse", cfg_rd, 8'h00);
        edges(RST_TICKS - 2);
        chk("R6 pulse still high", rst_req, 1);
        edges(1);
        chk("R6 pulse ended", rst_req, 0);
        clear_flag();
        edges(300);
        chk("R6 disabled after pulse", rst_req, 0);
        chk("R6 no flag after pulse", wd_flag, 0);

        // R8 power fail
        do_write(8'h0C);
        edges(12);
        chk("R8 irq armed", irq_req, 1);
        pwr_fail = 1'b1;
        edges(1);
        chk("R8 irq dropped", irq_req, 0);
        chk("R8 cfg cleared", cfg_rd, 8'h00);
        do_write(8'h0C);
        chk("R8 write held off", cfg_rd, 8'h00);
        pwr_fail = 1'b0;
        edges(100);
        chk("R8 stays disabled", irq_req, 0);
        clear_flag();

        // R10 reset mid-activity
        do_write(8'h0C);
        edges(12);
        rst = 1'b1;
        edges(1);
        chk("R10 irq after reset", irq_req, 0);
        chk("R10 flag after reset", wd_flag, 0);
        chk("R10 cfg after reset", cfg_rd, 0);
        rst = 1'b0;
        edges(2);
        finish_run();
    end
endmodule